// File: doc/BRIEF.md
# Non-preemptive interrupt task dispatcher

This block collects interrupt requests from four source classes: external, input, high-speed counter and scheduled. Each class has `LINES` numbered request lines. A rising edge on a line is latched as a pending request. When no interrupt task is running and dispatch is allowed, the block picks one pending request and hands its task number to the processor with a one-cycle valid pulse. The processor then runs that task to completion and returns a done pulse.

The `busy` output tells the background cyclic program to suspend. It goes high as soon as an enabled request is pending. It stays high while a task runs and across back-to-back tasks. It drops once nothing enabled is left to serve. Once a task has started, no request of any class can interrupt it. A pair of global off/on controls holds back dispatch so that a protected background operation can complete. Requests that arrive during that time are still latched.

Top module: `irq_dispatch`

## Requirements
- R1: After reset no request is pending, `busy`, `disp_valid` and `ovf` are low, and dispatch is allowed.
- R2: A rising edge on a request line marks it pending. A line held high counts as one request only. An enabled pending request raises `busy` in the cycle after the edge is sampled.
- R3: While a dispatched task has not returned `task_done`, `disp_valid` stays low, whatever new requests arrive.
- R4: The task number is `class*LINES + line`, with class codes 0 external, 1 input, 2 high-speed counter and 3 scheduled. Among requests pending together, a lower class code is served first.
- R5: Among requests of one class pending together, the lowest line number is served first.
- R6: A pulse on `irq_off` blocks new dispatches from the next cycle on. Requests keep being latched, and `busy` stays low while no task runs. A pulse on `irq_on` allows dispatch again, and everything latched is then served in R4/R5 order. If both pulses arrive in the same cycle, `irq_off` wins.
- R7: When `task_done` is sampled and another request is pending, the next `disp_valid` comes one clock edge later. `busy` stays high during the gap.
- R8: A rising edge on a line that is already pending sets that line's bit of `ovf` for one cycle. It merges into the existing request, so the task is dispatched once.
- R9: `busy` equals "task running, or dispatch allowed and a request pending". It falls in the cycle after the last `task_done`.
- R10: `task_done` while no task runs has no effect.
- R11: `disp_valid` lasts exactly one cycle. `disp_task` holds its value until the next dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ext | input | LINES | External-class request lines |
| req_inp | input | LINES | Input-class request lines |
| req_hsc | input | LINES | High-speed-counter-class request lines |
| req_sch | input | LINES | Scheduled-class request lines |
| irq_off | input | 1 | Pulse: block dispatch of new tasks |
| irq_on | input | 1 | Pulse: allow dispatch again |
| task_done | input | 1 | Pulse: running task has finished |
| disp_valid | output | 1 | One-cycle dispatch strobe |
| disp_task | output | TW | Number of the dispatched task |
| busy | output | 1 | Suspend the background task |
| ovf | output | 4*LINES | Per-line pulse: request merged into one already pending |

## Verification
The bench raises requests of several classes in the same cycle. A design with the wrong priority would serve them out of order, for example a scheduled task ahead of an external one, or a higher line ahead of a lower one. It sends a new external request while a task is held running, and preemption would show up as an early `disp_valid`. It sends requests while dispatch is off, sends a repeated edge on a line that is already pending, and pulses off and on in the same cycle. A design that dropped masked requests, dispatched a merged request twice, or let `irq_on` win would miss dispatches or add extra ones. It also checks the exact gap after `task_done` and a stray done while idle. A design that dispatched too early or too late, or that let `busy` drop between two tasks, would break the per-clock comparison against the reference model.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int LINES = 4,
  localparam int N = 4 * LINES,
  localparam int TW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_ext,
  input  logic [LINES-1:0] req_inp,
  input  logic [LINES-1:0] req_hsc,
  input  logic [LINES-1:0] req_sch,
  input  logic             irq_off,
  input  logic             irq_on,
  input  logic             task_done,
  output logic             disp_valid,
  output logic [TW-1:0]    disp_task,
  output logic             busy,
  output logic [N-1:0]     ovf
);

  logic [N-1:0]  req_all, prev, pend, rise, grant, clr;
  logic [TW-1:0] pick;
  logic          armed, running, go;

  assign req_all = {req_sch, req_hsc, req_inp, req_ext};
  assign rise    = req_all & ~prev;
  assign grant   = pend & (~pend + N'(1));
  assign go      = !running && armed && (|pend);
  assign clr     = go ? grant : '0;
  assign busy    = running | (armed & (|pend));

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend[i]) pick = TW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev       <= '0;
      pend       <= '0;
      ovf        <= '0;
      armed      <= 1'b1;
      running    <= 1'b0;
      disp_valid <= 1'b0;
      disp_task  <= '0;
    end else begin
      prev       <= req_all;
      pend       <= (pend & ~clr) | rise;
      ovf        <= rise & pend & ~clr;
      disp_valid <= go;
      if (go) disp_task <= pick;
      if (irq_off)     armed <= 1'b0;
      else if (irq_on) armed <= 1'b1;
      if (go)             running <= 1'b1;
      else if (task_done) running <= 1'b0;
    end
  end

endmodule

module irq_dispatch_chk #(
  parameter int LINES = 4,
  localparam int TW = $clog2(4 * LINES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          disp_valid,
  input logic [TW-1:0] disp_task,
  input logic          busy,
  input logic          task_done,
  input logic          armed
);

  logic live;
  always_ff @(posedge clk) begin
    if (!rst_n)          live <= 1'b0;
    else if (disp_valid) live <= 1'b1;
    else if (task_done)  live <= 1'b0;
  end

  // R3
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !live);

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !disp_valid);

  // R11
  task_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !disp_valid) |-> $stable(disp_task));

  // R6
  masked_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> $past(armed));

  // R9
  busy_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> busy);

endmodule

bind irq_dispatch irq_dispatch_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_task(disp_task),
  .busy(busy), .task_done(task_done), .armed(armed)
);

// File: tb/test_irq_dispatch.sv
`timescale 1ns/1ps
module test_irq_dispatch;
  localparam int L = 4;
  localparam int N = 4 * L;
  localparam int TW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic [L-1:0] r_ext = 0, r_inp = 0, r_hsc = 0, r_sch = 0;
  logic irq_off = 0, irq_on = 0, man_done = 0, auto_done = 0, hold = 0;
  wire  task_done = man_done | auto_done;
  logic disp_valid, busy;
  logic [TW-1:0] disp_task;
  logic [N-1:0] ovf;
  wire  [N-1:0] req_all = {r_sch, r_hsc, r_inp, r_ext};

  int checks = 0, errors = 0;
  int got[$];
  int exp_q[$];
  logic [N-1:0] ovf_seen = 0;
  bit prev_valid = 0, finished = 0;

  always #2.5 clk = ~clk;

  irq_dispatch #(.LINES(L)) i_irq_dispatch (
    .clk(clk), .rst_n(rst_n), .req_ext(r_ext), .req_inp(r_inp),
    .req_hsc(r_hsc), .req_sch(r_sch), .irq_off(irq_off), .irq_on(irq_on),
    .task_done(task_done), .disp_valid(disp_valid), .disp_task(disp_task),
    .busy(busy), .ovf(ovf));

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [N-1:0] m_prev, m_pend, m_ovf;
  bit m_en, m_run, m_valid;
  int m_task;
  always @(posedge clk) begin
    logic [N-1:0] e, c;
    bit go;
    int pk;
    if (!rst_n) begin
      m_prev = 0; m_pend = 0; m_ovf = 0; m_en = 1; m_run = 0; m_valid = 0; m_task = 0;
    end else begin
      e  = req_all & ~m_prev;
      go = !m_run && m_en && (m_pend != 0);
      pk = -1;
      for (int i = 0; i < N; i++) if (pk < 0 && m_pend[i]) pk = i;
      c = go ? (N'(1) << pk) : '0;
      m_ovf  = e & m_pend & ~c;
      m_pend = (m_pend & ~c) | e;
      m_prev = req_all;
      m_valid = go;
      if (go) m_task = pk;
      if (go) m_run = 1; else if (task_done) m_run = 0;
      if (irq_off) m_en = 0; else if (irq_on) m_en = 1;
    end
  end

  // per-clock comparison, monitor and processor emulation
  int cnt = 0;
  bit waiting = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(disp_valid == m_valid, "R11 valid", disp_valid, m_valid);
      chk(busy == (m_run || (m_en && m_pend != 0)), "R9 busy", busy, m_run || (m_en && m_pend != 0));
      chk(ovf == m_ovf, "R8 ovf", ovf, m_ovf);
      if (m_valid) chk(disp_task == m_task, "R4 task", disp_task, m_task);
      if (prev_valid) chk(!disp_valid, "R11 pulse", disp_valid, 0);
      prev_valid = disp_valid;
      ovf_seen |= ovf;
      if (disp_valid) got.push_back(int'(disp_task));
    end
    if (auto_done) auto_done = 0;
    else if (disp_valid) begin cnt = 2; waiting = 1; end
    else if (cnt > 0) cnt--;
    else if (waiting && !hold) begin auto_done = 1; waiting = 0; end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raise(logic [N-1:0] m, int width);
    @(negedge clk);
    {r_sch, r_hsc, r_inp, r_ext} = m;
    step(width);
    {r_sch, r_hsc, r_inp, r_ext} = 0;
  endtask

  task automatic expect_seq(string tag);
    chk(got.size() == exp_q.size(), tag, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      chk(got[i] == exp_q[i], tag, got[i], exp_q[i]);
    got.delete(); exp_q.delete();
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    if (!finished) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(4);
    rst_n = 1;
    step(1);
    chk(busy == 0 && disp_valid == 0 && ovf == 0, "R1 reset", {busy, disp_valid}, 0);

    // R2: held line gives one request
    raise(N'(1) << 2, 6);
    step(10);
    exp_q = '{2}; expect_seq("R2 single");
    chk(busy == 0, "R9 idle", busy, 0);

    // R4: cross-class order
    raise((N'(1) << 3) | (N'(1) << 4) | (N'(1) << 9) | (N'(1) << 12), 1);
    step(30);
    exp_q = '{3, 4, 9, 12}; expect_seq("R4 class order");

    // R5: same class
    raise((N'(1) << 15) | (N'(1) << 13), 1);
    step(15);
    exp_q = '{13, 15}; expect_seq("R5 line order");

    // R3: no preemption
    hold = 1;
    raise(N'(1) << 10, 1);
    step(4);
    raise(N'(1) << 0, 1);
    step(6);
    chk(got.size() == 1, "R3 no preempt", got.size(), 1);
    chk(busy == 1, "R3 busy", busy, 1);
    hold = 0;
    step(15);
    exp_q = '{10, 0}; expect_seq("R3 order");

    // R7: gap after done
    hold = 1;
    raise((N'(1) << 5) | (N'(1) << 6), 1);
    step(5);
    man_done = 1;
    step(1);
    man_done = 0;
    chk(disp_valid == 0 && busy == 1, "R7 gap", {disp_valid, busy}, 1);
    step(1);
    chk(disp_valid == 1 && disp_task == 6, "R7 next", disp_task, 6);
    hold = 0;
    step(10);
    exp_q = '{5, 6}; expect_seq("R7 seq");

    // R6: masking
    @(negedge clk); irq_off = 1; step(1); irq_off = 0;
    raise((N'(1) << 14) | (N'(1) << 1), 1);
    step(8);
    chk(got.size() == 0, "R6 masked", got.size(), 0);
    chk(busy == 0, "R6 busy low", busy, 0);
    irq_on = 1; step(1); irq_on = 0;
    step(15);
    exp_q = '{1, 14}; expect_seq("R6 release");

    // R8: merged request
    irq_off = 1; step(1); irq_off = 0;
    ovf_seen = 0;
    raise(N'(1) << 11, 1);
    step(2);
    raise(N'(1) << 11, 1);
    step(3);
    chk(ovf_seen[11] == 1, "R8 flag", ovf_seen[11], 1);
    irq_on = 1; step(1); irq_on = 0;
    step(15);
    exp_q = '{11}; expect_seq("R8 single dispatch");

    // R10: stray done
    man_done = 1; step(1); man_done = 0;
    step(3);
    chk(busy == 0 && got.size() == 0, "R10 idle done", busy, 0);
    raise(N'(1) << 7, 1);
    step(10);
    exp_q = '{7}; expect_seq("R10 normal after");
    chk(busy == 0, "R9 after last", busy, 0);

    // R6: simultaneous off and on
    irq_off = 1; irq_on = 1; step(1); irq_off = 0; irq_on = 0;
    raise(N'(1) << 0, 1);
    step(8);
    chk(got.size() == 0, "R6 off wins", got.size(), 0);
    irq_on = 1; step(1); irq_on = 0;
    step(10);
    exp_q = '{0}; expect_seq("R6 after on");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule